// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges four rectangular overlay layers into one stream of RGB pixels. A raster walker supplies the current x/y coordinate together with every layer's pixel colour and per-pixel alpha for that coordinate. The block returns one composed pixel per cycle, two cycles later.

Composition has two stages. In the first stage, each layer is steered into one of two pipes. Each pipe keeps only the covering layer with the highest priority. In the second stage, the upper pipe (pipe 1) is alpha-blended over the lower pipe (pipe 0), and pipe 0 in turn sits over a background colour. Transparency therefore exists only between the two pipes.

A static defect-emulation input reproduces a known hardware flaw. When it is set and the visible pipe-0 layer has priority 0 and is not fully opaque, that layer shows as background. Configuration is written through three write strobes: one for a per-layer word, one for the background colour and one for the display size.

Top module: `layer_compositor`

## Requirements
- R1: After reset, out_valid is 0, all layers are disabled and the background is black (24'h000000), so every in-frame pixel comes out as 24'h000000.
- R2: A layer covers pixel (x,y) only when it is enabled and x0 <= x < x0+w and y0 <= y < y0+h. A disabled layer never appears.
- R3: Within one pipe, the covering layer with the largest priority value wins. On equal priority, the layer with the lower index wins.
- R4: The output channel is (a*T + (255-a)*B + 127)/255 for each 8-bit channel (R in [23:16], G in [15:8], B in [7:0]). T is the pipe-1 winner's colour, a is its effective alpha, and B is the pipe-0 result.
- R5: Effective alpha is (p*g + 127)/255 when the layer's global-alpha enable is set, where p is the per-pixel alpha and g is the global alpha. When the enable is clear, the effective alpha is p alone.
- R6: The pipe-0 winner is drawn opaque whatever its alpha. When pipe 0 has no covering layer, B is the background colour. When pipe 1 has no covering layer, a is 0 and the output equals B.
- R7: With base_defect_en = 1, a pipe-0 winner of priority 0 whose effective alpha is below 255 is replaced by the background colour. An opaque winner, a winner of any other priority, or base_defect_en = 0 leaves the winner's colour in place.
- R8: A pixel presented with pix_valid in cycle n appears on out_valid/out_rgb after exactly two rising edges. No valid output occurs without a matching input.
- R9: A pixel with pix_x >= display width or pix_y >= display height produces out_valid = 0. The size word carries the width in [21:11] and the height in [10:0].
- R10: A cfg_wr updates only the layer selected by cfg_idx. The layer word is {enable[56], pipe[55], priority[54:53], global-alpha enable[52], global alpha[51:44], x0[43:33], y0[32:22], w[21:11], h[10:0]}. bg_wr loads the background colour from bg_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_defect_en | input | 1 | Enables the lowest-plane defect emulation |
| cfg_wr | input | 1 | Per-layer configuration write strobe |
| cfg_idx | input | 2 | Layer selected for writing |
| cfg_data | input | 57 | Per-layer configuration word |
| bg_wr | input | 1 | Background colour write strobe |
| bg_data | input | 24 | Background colour |
| size_wr | input | 1 | Display size write strobe |
| size_data | input | 22 | Display width and height |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 11 | Raster x coordinate |
| pix_y | input | 11 | Raster y coordinate |
| layer_rgb | input | 96 | Colour of each layer at this pixel, layer i in [24*i+23:24*i] |
| layer_a | input | 32 | Per-pixel alpha of each layer, layer i in [8*i+7:8*i] |
| out_valid | output | 1 | Composed pixel valid |
| out_rgb | output | 24 | Composed pixel colour |

## Verification
The assertions assume that the raster coordinate and the layer pixel inputs are driven to known values from time zero. They also assume that configuration writes can land between pixels, so the stage-one registers always hold a consistent winner for the pixel they carry. The bench initialises every input before reset is released. It changes configuration only while no pixel is in flight, and it sends one pixel at a time, so each expected value depends only on the configuration set up for that scenario.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;
  localparam int COORD_W = 11;
  localparam int PRIO_W  = 2;
  localparam int CH_W    = 8;
  localparam int RGB_W   = 3 * CH_W;
  localparam int A_MAX   = (1 << CH_W) - 1;
  localparam int PROD_W  = 2 * CH_W + 2;

  typedef struct packed {
    logic               en;
    logic               pipe;
    logic [PRIO_W-1:0]  prio;
    logic               ga_en;
    logic [CH_W-1:0]    ga;
    logic [COORD_W-1:0] x0;
    logic [COORD_W-1:0] y0;
    logic [COORD_W-1:0] w;
    logic [COORD_W-1:0] h;
  } layer_cfg_t;

  localparam int CFG_W = $bits(layer_cfg_t);

  // rounded product of two alpha values normalised to full scale
  function automatic logic [CH_W-1:0] scale_alpha(input logic [CH_W-1:0] a,
                                                  input logic [CH_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b) + PROD_W'(A_MAX / 2);
    return CH_W'(p / PROD_W'(A_MAX));
  endfunction

  // rounded weighted mix of one channel: a*top + (max-a)*bot
  function automatic logic [CH_W-1:0] mix_channel(input logic [CH_W-1:0] a,
                                                  input logic [CH_W-1:0] top,
                                                  input logic [CH_W-1:0] bot);
    logic [PROD_W-1:0] s;
    s = PROD_W'(a) * PROD_W'(top)
      + PROD_W'(CH_W'(A_MAX) - a) * PROD_W'(bot)
      + PROD_W'(A_MAX / 2);
    return CH_W'(s / PROD_W'(A_MAX));
  endfunction
endpackage

// File: rtl/layer_cfg_bank.sv
module layer_cfg_bank
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  localparam int IDX_W = $clog2(NUM_LAYERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 bg_wr,
  input  logic [RGB_W-1:0]     bg_data,
  input  logic                 size_wr,
  input  logic [2*COORD_W-1:0] size_data,
  output layer_cfg_t           cfg_q [NUM_LAYERS],
  output logic [RGB_W-1:0]     bg_q,
  output logic [COORD_W-1:0]   disp_w,
  output logic [COORD_W-1:0]   disp_h
);
  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_q[i] <= '0;
      else if (cfg_wr && cfg_idx == IDX_W'(i))   cfg_q[i] <= layer_cfg_t'(cfg_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q   <= '0;
      disp_w <= '0;
      disp_h <= '0;
    end else begin
      if (bg_wr) bg_q <= bg_data;
      if (size_wr) begin
        disp_w <= size_data[2*COORD_W-1:COORD_W];
        disp_h <= size_data[COORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pipe_select.sv
module pipe_select
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int PIPE_ID    = 0
) (
  input  layer_cfg_t                  cfg [NUM_LAYERS],
  input  logic [COORD_W-1:0]          x,
  input  logic [COORD_W-1:0]          y,
  input  logic [NUM_LAYERS*RGB_W-1:0] layer_rgb,
  input  logic [NUM_LAYERS*CH_W-1:0]  layer_a,
  output logic                        cov,
  output logic [RGB_W-1:0]            win_rgb,
  output logic [CH_W-1:0]             win_a,
  output logic [PRIO_W-1:0]           win_prio,
  output logic [NUM_LAYERS-1:0]       win_oh
);
  logic [NUM_LAYERS-1:0] hit;
  logic [CH_W-1:0]       eff_a [NUM_LAYERS];

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_hit
    logic [COORD_W:0] x_end, y_end;
    logic [CH_W-1:0]  pa;
    assign x_end = {1'b0, cfg[i].x0} + {1'b0, cfg[i].w};
    assign y_end = {1'b0, cfg[i].y0} + {1'b0, cfg[i].h};
    assign hit[i] = cfg[i].en && (cfg[i].pipe == 1'(PIPE_ID))
                 && (x >= cfg[i].x0) && ({1'b0, x} < x_end)
                 && (y >= cfg[i].y0) && ({1'b0, y} < y_end);
    assign pa       = layer_a[i*CH_W +: CH_W];
    assign eff_a[i] = cfg[i].ga_en ? scale_alpha(pa, cfg[i].ga) : pa;
  end

  // walk upward in index; strictly larger priority replaces, so ties keep the lower index
  always_comb begin
    cov      = 1'b0;
    win_rgb  = '0;
    win_a    = '0;
    win_prio = '0;
    win_oh   = '0;
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (hit[i] && (!cov || cfg[i].prio > win_prio)) begin
        cov       = 1'b1;
        win_prio  = cfg[i].prio;
        win_rgb   = layer_rgb[i*RGB_W +: RGB_W];
        win_a     = eff_a[i];
        win_oh    = '0;
        win_oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixel_mixer.sv
module pixel_mixer
  import lcomp_pkg::*;
(
  input  logic [CH_W-1:0]  alpha,
  input  logic [RGB_W-1:0] top,
  input  logic [RGB_W-1:0] bot,
  output logic [RGB_W-1:0] mixed
);
  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign mixed[c*CH_W +: CH_W] =
      mix_channel(alpha, top[c*CH_W +: CH_W], bot[c*CH_W +: CH_W]);
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  localparam int IDX_W = $clog2(NUM_LAYERS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        base_defect_en,
  input  logic                        cfg_wr,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [CFG_W-1:0]            cfg_data,
  input  logic                        bg_wr,
  input  logic [RGB_W-1:0]            bg_data,
  input  logic                        size_wr,
  input  logic [2*COORD_W-1:0]        size_data,
  input  logic                        pix_valid,
  input  logic [COORD_W-1:0]          pix_x,
  input  logic [COORD_W-1:0]          pix_y,
  input  logic [NUM_LAYERS*RGB_W-1:0] layer_rgb,
  input  logic [NUM_LAYERS*CH_W-1:0]  layer_a,
  output logic                        out_valid,
  output logic [RGB_W-1:0]            out_rgb
);
  localparam int NUM_PIPES = 2;

  layer_cfg_t         cfg_q [NUM_LAYERS];
  logic [RGB_W-1:0]   bg_q;
  logic [COORD_W-1:0] disp_w, disp_h;

  layer_cfg_bank #(.NUM_LAYERS(NUM_LAYERS)) i_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .bg_wr(bg_wr), .bg_data(bg_data),
    .size_wr(size_wr), .size_data(size_data),
    .cfg_q(cfg_q), .bg_q(bg_q), .disp_w(disp_w), .disp_h(disp_h)
  );

  logic                  p_cov  [NUM_PIPES];
  logic [RGB_W-1:0]      p_rgb  [NUM_PIPES];
  logic [CH_W-1:0]       p_a    [NUM_PIPES];
  logic [PRIO_W-1:0]     p_prio [NUM_PIPES];
  logic [NUM_LAYERS-1:0] p_oh   [NUM_PIPES];

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    pipe_select #(.NUM_LAYERS(NUM_LAYERS), .PIPE_ID(p)) i_sel (
      .cfg(cfg_q), .x(pix_x), .y(pix_y),
      .layer_rgb(layer_rgb), .layer_a(layer_a),
      .cov(p_cov[p]), .win_rgb(p_rgb[p]), .win_a(p_a[p]),
      .win_prio(p_prio[p]), .win_oh(p_oh[p])
    );
  end

  // named events for the checker
  logic [NUM_LAYERS-1:0] winner_oh0, winner_oh1, layer_en_vec;
  logic                  defect_hit, in_frame;
  assign winner_oh0 = p_oh[0];
  assign winner_oh1 = p_oh[1];
  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_en
    assign layer_en_vec[i] = cfg_q[i].en;
  end

  assign defect_hit = base_defect_en && p_cov[0] && (p_prio[0] == '0)
                   && (p_a[0] != CH_W'(A_MAX));
  assign in_frame   = (pix_x < disp_w) && (pix_y < disp_h);

  logic [RGB_W-1:0] bot_rgb;
  assign bot_rgb = (!p_cov[0] || defect_hit) ? bg_q : p_rgb[0];

  // stage 1: per-pipe winners
  logic             s1_valid, s1_top_cov;
  logic [CH_W-1:0]  s1_top_a;
  logic [RGB_W-1:0] s1_top_rgb, s1_bot_rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_top_cov <= 1'b0;
      s1_top_a   <= '0;
      s1_top_rgb <= '0;
      s1_bot_rgb <= '0;
    end else begin
      s1_valid   <= pix_valid && in_frame;
      s1_top_cov <= p_cov[1];
      s1_top_a   <= p_cov[1] ? p_a[1] : '0;
      s1_top_rgb <= p_rgb[1];
      s1_bot_rgb <= bot_rgb;
    end
  end

  // stage 2: blend between pipes
  logic [RGB_W-1:0] mixed;
  pixel_mixer i_mix (.alpha(s1_top_a), .top(s1_top_rgb), .bot(s1_bot_rgb), .mixed(mixed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_rgb   <= mixed;
    end
  end
endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk
  import lcomp_pkg::*;
#(
  parameter int NUM_LAYERS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_valid,
  input logic                  out_valid,
  input logic [RGB_W-1:0]      out_rgb,
  input logic [NUM_LAYERS-1:0] winner_oh0,
  input logic [NUM_LAYERS-1:0] winner_oh1,
  input logic [NUM_LAYERS-1:0] layer_en_vec,
  input logic                  s1_valid,
  input logic                  s1_top_cov,
  input logic [CH_W-1:0]       s1_top_a,
  input logic [RGB_W-1:0]      s1_top_rgb,
  input logic [RGB_W-1:0]      s1_bot_rgb
);
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid, 2));

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner_oh0) && $onehot0(winner_oh1));

  assert_pipes_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (winner_oh0 & winner_oh1) == '0);

  assert_no_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((winner_oh0 | winner_oh1) & ~layer_en_vec) == '0);

  assert_transparent_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_top_cov) |=> out_rgb == $past(s1_bot_rgb));

  assert_opaque_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_top_cov && s1_top_a == CH_W'(A_MAX)) |=> out_rgb == $past(s1_top_rgb));
endmodule

bind layer_compositor layer_compositor_chk #(.NUM_LAYERS(NUM_LAYERS)) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
  .out_valid(out_valid), .out_rgb(out_rgb),
  .winner_oh0(winner_oh0), .winner_oh1(winner_oh1), .layer_en_vec(layer_en_vec),
  .s1_valid(s1_valid), .s1_top_cov(s1_top_cov), .s1_top_a(s1_top_a),
  .s1_top_rgb(s1_top_rgb), .s1_bot_rgb(s1_bot_rgb)
);

// File: tb/test_layer_compositor.sv
module test_layer_compositor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_defect_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [56:0] cfg_data = '0;
  logic        bg_wr = 1'b0;
  logic [23:0] bg_data = '0;
  logic        size_wr = 1'b0;
  logic [21:0] size_data = '0;
  logic        pix_valid = 1'b0;
  logic [10:0] pix_x = '0, pix_y = '0;
  logic [95:0] layer_rgb = '0;
  logic [31:0] layer_a = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0, failures = 0;
  bit reported = 0;

  localparam logic [23:0] C0 = 24'h102030, C1 = 24'hA0B0C0,
                          C2 = 24'hFF8000, BG = 24'h202020;

  always #5 clk = ~clk;

  layer_compositor i_layer_compositor (.*);

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int e_scale(int a, int b);
    return (a * b + 127) / 255;
  endfunction

  function automatic logic [23:0] e_mix(int a, logic [23:0] t, logic [23:0] b);
    logic [23:0] r = '0;
    for (int c = 0; c < 3; c++) begin
      int tv = int'(t[8*c +: 8]);
      int bv = int'(b[8*c +: 8]);
      r[8*c +: 8] = 8'((tv * a + bv * (255 - a) + 127) / 255);
    end
    return r;
  endfunction

  task automatic set_layer(int idx, bit en, bit pipe, int prio, bit gaen, int ga,
                           int x0, int y0, int w, int h);
    @(negedge clk);
    cfg_idx  = 2'(idx);
    cfg_data = {en, pipe, 2'(prio), gaen, 8'(ga), 11'(x0), 11'(y0), 11'(w), 11'(h)};
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic set_bg(logic [23:0] c);
    @(negedge clk); bg_data = c; bg_wr = 1'b1;
    @(negedge clk); bg_wr = 1'b0;
  endtask

  task automatic set_pix(int idx, logic [23:0] rgb, int a);
    layer_rgb[idx*24 +: 24] = rgb;
    layer_a[idx*8 +: 8]     = 8'(a);
  endtask

  task automatic clear_layers();
    for (int i = 0; i < 4; i++) set_layer(i, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic probe(int x, int y, output logic vmid, output logic v, output logic [23:0] rgb);
    @(negedge clk);
    pix_x = 11'(x); pix_y = 11'(y); pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    vmid = out_valid;
    @(negedge clk);
    v = out_valid; rgb = out_rgb;
  endtask

  task automatic expect_pix(string req, string what, int x, int y, logic [23:0] exp);
    logic vm, v; logic [23:0] r;
    probe(x, y, vm, v, r);
    check(req, {what, " valid"}, 32'(v), 32'd1);
    check(req, what, 32'(r), 32'(exp));
  endtask

  task automatic t_reset();
    check("R1", "out_valid in reset", 32'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", 32'(out_valid), 0);
    check("R1", "out_rgb after reset", 32'(out_rgb), 0);
    @(negedge clk); size_data = {11'd64, 11'd48}; size_wr = 1'b1;
    @(negedge clk); size_wr = 1'b0;
    expect_pix("R1", "empty frame black", 5, 5, 24'h0);
  endtask

  task automatic t_background();
    set_bg(BG);
    expect_pix("R10", "background write", 7, 9, BG);
    set_layer(0, 0, 0, 3, 0, 0, 0, 0, 64, 48);
    set_pix(0, C0, 255);
    expect_pix("R2", "disabled layer hidden", 7, 9, BG);
  endtask

  task automatic t_coverage();
    clear_layers();
    set_layer(0, 1, 0, 0, 0, 0, 10, 20, 4, 3);
    set_pix(0, C0, 255);
    expect_pix("R2", "left of x0", 9, 20, BG);
    expect_pix("R2", "x0 edge", 10, 20, C0);
    expect_pix("R2", "last column", 13, 22, C0);
    expect_pix("R2", "x0+w excluded", 14, 20, BG);
    expect_pix("R2", "y0+h excluded", 11, 23, BG);
  endtask

  task automatic t_priority();
    clear_layers();
    set_pix(0, C0, 255); set_pix(1, C1, 255);
    set_layer(0, 1, 0, 1, 0, 0, 0, 0, 64, 48);
    set_layer(1, 1, 0, 3, 0, 0, 0, 0, 64, 48);
    expect_pix("R3", "higher priority wins", 3, 3, C1);
    set_layer(1, 1, 0, 1, 0, 0, 0, 0, 64, 48);
    expect_pix("R3", "tie to lower index", 3, 3, C0);
  endtask

  task automatic t_blend();
    clear_layers();
    set_layer(0, 1, 0, 0, 0, 0, 0, 0, 64, 48);
    set_layer(2, 1, 1, 0, 0, 0, 0, 0, 64, 48);
    set_pix(0, C0, 255);
    set_pix(2, C2, 128);
    expect_pix("R4", "half alpha mix", 4, 4, e_mix(128, C2, C0));
    set_pix(2, C2, 255);
    expect_pix("R4", "opaque top", 4, 4, C2);
    set_pix(2, C2, 0);
    expect_pix("R4", "clear top", 4, 4, C0);
  endtask

  task automatic t_global_alpha();
    set_pix(2, C2, 200);
    set_layer(2, 1, 1, 0, 1, 128, 0, 0, 64, 48);
    expect_pix("R5", "global alpha scaled", 4, 4, e_mix(e_scale(200, 128), C2, C0));
    set_layer(2, 1, 1, 0, 0, 10, 0, 0, 64, 48);
    expect_pix("R5", "global alpha off", 4, 4, e_mix(200, C2, C0));
  endtask

  task automatic t_pipe_rules();
    clear_layers();
    set_layer(0, 1, 0, 0, 0, 0, 0, 0, 64, 48);
    set_pix(0, C0, 0);
    expect_pix("R6", "pipe0 alpha ignored", 2, 2, C0);
    clear_layers();
    set_layer(2, 1, 1, 0, 0, 0, 0, 0, 64, 48);
    set_pix(2, C2, 128);
    expect_pix("R6", "top over background", 2, 2, e_mix(128, C2, BG));
  endtask

  task automatic t_defect();
    clear_layers();
    base_defect_en = 1'b1;
    set_layer(0, 1, 0, 0, 0, 0, 0, 0, 64, 48);
    set_pix(0, C0, 100);
    expect_pix("R7", "translucent prio0 shows bg", 6, 6, BG);
    set_pix(0, C0, 255);
    expect_pix("R7", "opaque prio0 kept", 6, 6, C0);
    set_pix(0, C0, 100);
    set_layer(0, 1, 0, 1, 0, 0, 0, 0, 64, 48);
    expect_pix("R7", "prio1 unaffected", 6, 6, C0);
    set_layer(0, 1, 0, 0, 0, 0, 0, 0, 64, 48);
    base_defect_en = 1'b0;
    expect_pix("R7", "defect mode off", 6, 6, C0);
  endtask

  task automatic t_latency();
    logic vm, v; logic [23:0] r;
    probe(1, 1, vm, v, r);
    check("R8", "not valid after one edge", 32'(vm), 0);
    check("R8", "valid after two edges", 32'(v), 1);
    @(negedge clk);
    check("R8", "single output beat", 32'(out_valid), 0);
  endtask

  task automatic t_frame();
    logic vm, v; logic [23:0] r;
    probe(64, 10, vm, v, r);
    check("R9", "x at width dropped", 32'(v), 0);
    probe(10, 48, vm, v, r);
    check("R9", "y at height dropped", 32'(v), 0);
    expect_pix("R9", "last in-frame pixel", 63, 47, C0);
  endtask

  task automatic t_isolation();
    set_layer(1, 0, 1, 3, 0, 0, 0, 0, 0, 0);
    expect_pix("R10", "other layer untouched", 8, 8, C0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_background();
    t_coverage();
    t_priority();
    t_blend();
    t_global_alpha();
    t_pipe_rules();
    t_defect();
    t_latency();
    t_frame();
    t_isolation();
    report();
  end
endmodule